// File: doc/BRIEF.md
# Embedded Operation Status Generator

This block forms the status bits that a flash device places on its data bus while an internal program or erase is in progress. It also produces the ready/busy indication. The engine supplies four things: the kind of operation, a busy flag, a timeout flag and the last data byte written. The host bus supplies its two active-low read strobes, output enable and chip enable. A single-cycle pulse marks the rising edge of the last write-enable pulse of a command sequence. From that point on, the status bits are meaningful.

The block has four status outputs.

- The polling bit (bit 7 position) reports completion by returning either the complement or the true value of the last written bit.
- The toggle bit (bit 6 position) flips once per completed read while work is pending.
- The limit bit (bit 5 position) reports that the engine exceeded its internal time budget.
- Ready/busy is an open-drain signal. It is modelled as a drive-low enable, so that the outputs of several devices can be combined as a wired-AND on a pulled-up net.

Top module: `flash_status_gen`

## Requirements
- R1: With status valid and operation code 1 (program), the polling bit is the inverse of bit DATA_W-1 of the last written byte while busy is high, and equals that bit once busy is low.
- R2: With status valid and operation code 2 (erase), the polling bit is 0 while busy is high and 1 once busy is low. With code 3 (erase suspended) it is 1.
- R3: With status valid, busy high and operation code 1 or 2, each completed read flips the toggle bit exactly once. A read is completed when either strobe returns high after a period in which both strobes were low. The flip appears SYNC_STAGES+1 clock edges after the strobe rises.
- R4: With busy low, or with operation code 0 or 3, reads leave the toggle bit unchanged.
- R5: The limit bit is set one cycle after the timeout input is high while the operation code is not 0. It stays set until the operation code returns to 0 (idle), and then reads 0.
- R6: The drive-low enable is 1 one cycle after busy is high with operation code 1 or 2. This includes a program started from within an erase suspend, which the engine reports as code 1.
- R7: The drive-low enable is 0 one cycle after busy is low, or after the operation code is 0 or 3.
- R8: Status valid rises one cycle after the sequence-done pulse and clears one cycle after the operation code is 0. While status is not valid, the polling bit carries the true last-written bit and reads do not flip the toggle bit.
- R9: After a synchronous reset, all status outputs and the drive-low enable are 0.
- R10: Several devices can share one ready/busy net. The net is high only when no device drives it low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_mode_i | input | 2 | Operation code: 0 idle, 1 program, 2 erase, 3 erase suspended |
| eng_busy_i | input | 1 | Engine is executing the operation |
| eng_timeout_i | input | 1 | Engine exceeded its internal time limit |
| seq_done_i | input | 1 | Pulse at the final write-enable rising edge of a command |
| last_data_i | input | DATA_W | Last byte handed to the program engine |
| oe_n_i | input | 1 | Output enable strobe, active low, asynchronous |
| ce_n_i | input | 1 | Chip enable strobe, active low, asynchronous |
| q7_o | output | 1 | Polling bit |
| q6_o | output | 1 | Toggle bit |
| q5_o | output | 1 | Time-limit-exceeded bit |
| stat_vld_o | output | 1 | Status bits are meaningful |
| rb_low_o | output | 1 | Drive-low enable of the open-drain ready/busy pin |

## Verification
The assertions check the following on every clock edge:

- the polling-bit value for program and erase once status is valid;
- the hold of the toggle bit whenever no operation is busy;
- the setting of the limit bit;
- the ready/busy enable for the busy, suspended and idle cases.

Some behaviours can only be shown by the bench's read scenarios. These are:

- that one completed read yields exactly one flip after the synchronizer delay, whichever strobe ends the read;
- that no flip occurs before the sequence-done pulse;
- the wired-AND of two devices on a shared ready/busy net.

The bench also sweeps every combination of operation code, busy, data bit and validity.

// File: rtl/flst_pkg.sv
package flst_pkg;
  typedef enum logic [1:0] {
    OPK_IDLE  = 2'd0,
    OPK_PROG  = 2'd1,
    OPK_ERASE = 2'd2,
    OPK_SUSP  = 2'd3
  } op_kind_e;

  function automatic logic op_is_work(input logic [1:0] code);
    return (code == OPK_PROG) || (code == OPK_ERASE);
  endfunction
endpackage

// File: rtl/flst_strobe_sync.sv
module flst_strobe_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n_i,
  input  logic ce_n_i,
  output logic rd_end_o
);
  localparam int NUM_STROBES = 2;

  logic [NUM_STROBES-1:0] raw_n;
  logic [NUM_STROBES-1:0] synced_n;
  logic                   rd_act_q;
  logic                   rd_act;

  assign raw_n = {ce_n_i, oe_n_i};

  for (genvar s = 0; s < NUM_STROBES; s++) begin : g_strobe
    logic [SYNC_STAGES-1:0] chain_q;
    always_ff @(posedge clk) begin
      if (rst) begin
        chain_q <= '1;
      end else begin
        chain_q <= {chain_q[SYNC_STAGES-2:0], raw_n[s]};
      end
    end
    assign synced_n[s] = chain_q[SYNC_STAGES-1];
  end

  // A read is in progress only while every strobe is low.
  assign rd_act = ~|synced_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
    end else begin
      rd_act_q <= rd_act;
    end
  end

  // The read ends when whichever strobe returns high first.
  assign rd_end_o = rd_act_q & ~rd_act;
endmodule

// File: rtl/flst_poll.sv
module flst_poll #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_mode_i,
  input  logic              eng_busy_i,
  input  logic              eng_timeout_i,
  input  logic              seq_done_i,
  input  logic [DATA_W-1:0] last_data_i,
  output logic              armed_o,
  output logic              q7_o,
  output logic              q5_o
);
  import flst_pkg::*;

  localparam int POLL_BIT = DATA_W - 1;

  logic armed_q;
  logic q7_q;
  logic q5_q;
  logic q7_next;
  logic d_bit;

  assign d_bit = last_data_i[POLL_BIT];

  always_comb begin
    q7_next = d_bit;
    if (armed_q) begin
      case (op_kind_e'(op_mode_i))
        OPK_PROG:  q7_next = eng_busy_i ? ~d_bit : d_bit;
        OPK_ERASE: q7_next = ~eng_busy_i;
        OPK_SUSP:  q7_next = 1'b1;
        default:   q7_next = d_bit;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      armed_q <= 1'b0;
      q7_q    <= 1'b0;
      q5_q    <= 1'b0;
    end else begin
      if (seq_done_i) begin
        armed_q <= 1'b1;
      end else if (op_mode_i == OPK_IDLE) begin
        armed_q <= 1'b0;
      end
      q7_q <= q7_next;
      if (op_mode_i == OPK_IDLE) begin
        q5_q <= 1'b0;
      end else if (eng_timeout_i) begin
        q5_q <= 1'b1;
      end
    end
  end

  assign armed_o = armed_q;
  assign q7_o    = q7_q;
  assign q5_o    = q5_q;
endmodule

// File: rtl/flst_toggle.sv
module flst_toggle (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] op_mode_i,
  input  logic       eng_busy_i,
  input  logic       armed_i,
  input  logic       rd_end_i,
  output logic       q6_o
);
  import flst_pkg::*;

  logic q6_q;
  logic flip;

  assign flip = rd_end_i & armed_i & eng_busy_i & op_is_work(op_mode_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      q6_q <= 1'b0;
    end else if (flip) begin
      q6_q <= ~q6_q;
    end
  end

  assign q6_o = q6_q;
endmodule

// File: rtl/flst_rdy.sv
module flst_rdy (
  input  logic       clk,
  input  logic       rst,
  input  logic [1:0] op_mode_i,
  input  logic       eng_busy_i,
  output logic       rb_low_o
);
  import flst_pkg::*;

  logic rb_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      rb_q <= 1'b0;
    end else begin
      rb_q <= eng_busy_i & op_is_work(op_mode_i);
    end
  end

  assign rb_low_o = rb_q;
endmodule

// File: rtl/flash_status_gen.sv
module flash_status_gen #(
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [1:0]        op_mode_i,
  input  logic              eng_busy_i,
  input  logic              eng_timeout_i,
  input  logic              seq_done_i,
  input  logic [DATA_W-1:0] last_data_i,
  input  logic              oe_n_i,
  input  logic              ce_n_i,
  output logic              q7_o,
  output logic              q6_o,
  output logic              q5_o,
  output logic              stat_vld_o,
  output logic              rb_low_o
);
  logic rd_end;
  logic armed;

  flst_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst      (rst),
    .oe_n_i   (oe_n_i),
    .ce_n_i   (ce_n_i),
    .rd_end_o (rd_end)
  );

  flst_poll #(.DATA_W(DATA_W)) u_poll (
    .clk           (clk),
    .rst           (rst),
    .op_mode_i     (op_mode_i),
    .eng_busy_i    (eng_busy_i),
    .eng_timeout_i (eng_timeout_i),
    .seq_done_i    (seq_done_i),
    .last_data_i   (last_data_i),
    .armed_o       (armed),
    .q7_o          (q7_o),
    .q5_o          (q5_o)
  );

  flst_toggle u_tog (
    .clk        (clk),
    .rst        (rst),
    .op_mode_i  (op_mode_i),
    .eng_busy_i (eng_busy_i),
    .armed_i    (armed),
    .rd_end_i   (rd_end),
    .q6_o       (q6_o)
  );

  flst_rdy u_rdy (
    .clk        (clk),
    .rst        (rst),
    .op_mode_i  (op_mode_i),
    .eng_busy_i (eng_busy_i),
    .rb_low_o   (rb_low_o)
  );

  assign stat_vld_o = armed;
endmodule

// File: rtl/flash_status_gen_chk.sv
module flash_status_gen_chk #(
  parameter int DATA_W = 8
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        op_mode_i,
  input logic              eng_busy_i,
  input logic              eng_timeout_i,
  input logic [DATA_W-1:0] last_data_i,
  input logic              q7_o,
  input logic              q6_o,
  input logic              q5_o,
  input logic              stat_vld_o,
  input logic              rb_low_o
);
  // R1
  prog_poll_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_vld_o && op_mode_i == 2'd1) |=>
      (q7_o == ($past(eng_busy_i) ? ~$past(last_data_i[DATA_W-1]) : $past(last_data_i[DATA_W-1]))));

  // R2
  erase_poll_chk: assert property (@(posedge clk) disable iff (rst)
    (stat_vld_o && op_mode_i == 2'd2) |=> (q7_o == !$past(eng_busy_i)));

  // R4
  toggle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!eng_busy_i || op_mode_i == 2'd0 || op_mode_i == 2'd3) |=> $stable(q6_o));

  // R5
  limit_set_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_timeout_i && op_mode_i != 2'd0) |=> q5_o);

  // R5
  limit_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (op_mode_i == 2'd0) |=> !q5_o);

  // R6
  rb_busy_chk: assert property (@(posedge clk) disable iff (rst)
    (eng_busy_i && (op_mode_i == 2'd1 || op_mode_i == 2'd2)) |=> rb_low_o);

  // R7
  rb_ready_chk: assert property (@(posedge clk) disable iff (rst)
    (!eng_busy_i || op_mode_i == 2'd0 || op_mode_i == 2'd3) |=> !rb_low_o);
endmodule

bind flash_status_gen flash_status_gen_chk #(.DATA_W(DATA_W)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .op_mode_i     (op_mode_i),
  .eng_busy_i    (eng_busy_i),
  .eng_timeout_i (eng_timeout_i),
  .last_data_i   (last_data_i),
  .q7_o          (q7_o),
  .q6_o          (q6_o),
  .q5_o          (q5_o),
  .stat_vld_o    (stat_vld_o),
  .rb_low_o      (rb_low_o)
);

// File: tb/flash_status_gen_tb_top.sv
module flash_status_gen_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int DW         = 8;
  localparam int SS         = 2;
  localparam int SETTLE     = SS + 3;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [1:0] op_a = 2'd0, op_b = 2'd0;
  logic busy_a = 1'b0, busy_b = 1'b0;
  logic tmo = 1'b0, seq = 1'b0;
  logic [DW-1:0] data = '0;
  logic oe_n = 1'b1, ce_n = 1'b1;
  logic q7, q6, q5, vld, rb_a;
  logic q7b, q6b, q5b, vldb, rb_b;
  logic wired_rb;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  flash_status_gen #(.DATA_W(DW), .SYNC_STAGES(SS)) dut_i (
    .clk(clk), .rst(rst), .op_mode_i(op_a), .eng_busy_i(busy_a),
    .eng_timeout_i(tmo), .seq_done_i(seq), .last_data_i(data),
    .oe_n_i(oe_n), .ce_n_i(ce_n), .q7_o(q7), .q6_o(q6), .q5_o(q5),
    .stat_vld_o(vld), .rb_low_o(rb_a));

  flash_status_gen #(.DATA_W(DW), .SYNC_STAGES(SS)) dut2_i (
    .clk(clk), .rst(rst), .op_mode_i(op_b), .eng_busy_i(busy_b),
    .eng_timeout_i(1'b0), .seq_done_i(1'b0), .last_data_i(data),
    .oe_n_i(1'b1), .ce_n_i(1'b1), .q7_o(q7b), .q6_o(q6b), .q5_o(q5b),
    .stat_vld_o(vldb), .rb_low_o(rb_b));

  // Pulled-up net: any enabled device pulls it low.
  assign wired_rb = ~(rb_a | rb_b);

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string req, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0b expected %0b", req, act, exp);
    end
  endtask

  task automatic read_oe();
    ce_n = 1'b0; oe_n = 1'b0; cyc(2);
    oe_n = 1'b1; cyc(SETTLE);
    ce_n = 1'b1; cyc(1);
  endtask

  task automatic read_ce();
    oe_n = 1'b0; ce_n = 1'b0; cyc(2);
    ce_n = 1'b1; cyc(SETTLE);
    oe_n = 1'b1; cyc(1);
  endtask

  task automatic go_idle();
    op_a = 2'd0; busy_a = 1'b0; cyc(2);
  endtask

  task automatic start(input logic [1:0] op, input logic arm);
    go_idle();
    op_a = op; busy_a = 1'b1;
    if (arm) begin seq = 1'b1; cyc(1); seq = 1'b0; end
    cyc(2);
  endtask

  initial begin
    cyc(CLK_PERIOD * 10000);
    if (!done) begin
      fails++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic e7, prev;
    cyc(3);
    // R9 reset state
    chk("R9 q7", q7, 1'b0); chk("R9 q6", q6, 1'b0); chk("R9 q5", q5, 1'b0);
    chk("R9 vld", vld, 1'b0); chk("R9 rb", rb_a, 1'b0);
    rst = 1'b0; cyc(2);

    // Sweep of op code, busy, data bit and validity: R1 R2 R6 R7 R8
    for (int op = 0; op < 4; op++)
      for (int b = 0; b < 2; b++)
        for (int d = 0; d < 2; d++)
          for (int a = 0; a < 2; a++) begin
            go_idle();
            data = d[0] ? 8'h80 : 8'h3C;
            op_a = op[1:0]; busy_a = b[0];
            if (a != 0) begin seq = 1'b1; cyc(1); seq = 1'b0; end
            cyc(2);
            if (a == 0 || op == 0) e7 = d[0];
            else if (op == 1) e7 = b[0] ? ~d[0] : d[0];
            else if (op == 2) e7 = ~b[0];
            else e7 = 1'b1;
            chk((op == 2 || op == 3) ? "R2 poll" : "R1 poll", q7, e7);
            chk("R8 valid", vld, (a != 0) && (op != 0));
            chk(b[0] ? "R6 rb" : "R7 rb", rb_a, b[0] && (op == 1 || op == 2));
          end

    // R3 toggle on reads during program, ended by either strobe
    start(2'd1, 1'b1);
    for (int i = 0; i < 3; i++) begin
      prev = q6; read_oe(); chk("R3 oe flip", q6, ~prev);
    end
    for (int i = 0; i < 3; i++) begin
      prev = q6; read_ce(); chk("R3 ce flip", q6, ~prev);
    end
    // R3 single read flips after SS+1 edges, not earlier
    prev = q6;
    ce_n = 1'b0; oe_n = 1'b0; cyc(2); oe_n = 1'b1;
    cyc(SS); chk("R3 early", q6, prev);
    cyc(1);  chk("R3 timing", q6, ~prev);
    ce_n = 1'b1; cyc(2);
    // R3 during erase
    start(2'd2, 1'b1);
    prev = q6; read_oe(); chk("R3 erase flip", q6, ~prev);
    // R4 complete: no flip
    busy_a = 1'b0; cyc(2);
    prev = q6; read_oe(); chk("R4 done hold", q6, prev);
    // R4 suspend: no flip
    op_a = 2'd3; busy_a = 1'b1; cyc(2);
    prev = q6; read_ce(); chk("R4 suspend hold", q6, prev);
    chk("R7 suspend rb", rb_a, 1'b0);
    // R6 program inside erase suspend reported as program
    op_a = 2'd1; cyc(2);
    chk("R6 prog in suspend rb", rb_a, 1'b1);
    // R8 not yet valid: no flip
    start(2'd1, 1'b0);
    prev = q6; read_oe(); chk("R8 unarmed hold", q6, prev);

    // R5 limit bit sticky until idle
    start(2'd1, 1'b1);
    chk("R5 initial", q5, 1'b0);
    tmo = 1'b1; cyc(1); tmo = 1'b0; cyc(1);
    chk("R5 set", q5, 1'b1);
    cyc(3); chk("R5 sticky", q5, 1'b1);
    go_idle(); chk("R5 clear", q5, 1'b0);

    // R10 wired-AND of two devices
    for (int k = 0; k < 4; k++) begin
      op_a = 2'd2; busy_a = k[0];
      op_b = 2'd1; busy_b = k[1];
      cyc(2);
      chk("R10 wired", wired_rb, !(k[0] || k[1]));
    end

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule